// File: doc/BRIEF.md
# Byte-wide SPI master with programmable transfer time

This block is a byte-wide SPI master that a CPU drives through two registers: a 16-bit control register and an 8-bit data register. A write to the data register, when the block is enabled, starts a one-byte transfer to the slave chosen by the chip-select field. The block presents the outgoing byte with a one-cycle strobe and raises busy. It then counts a number of clock cycles that is a power-of-two fraction of the system clock rate, chosen by a 2-bit rate field. At the end of the count it captures the byte that the selected slave returns into the data register, clears busy and can give a one-cycle interrupt pulse.

A hold bit in the control register decides whether a slave keeps its command state across control writes. A control write made while the previously stored hold bit was clear sends a one-cycle command-clear pulse to the slave named in the new write. A data write made during a transfer abandons that transfer and starts the count again from zero.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After reset, ctrl_q reads 0x0000, data_q reads 0x00, and irq_pulse, tx_strobe, dev_sel and cmd_clr are all low.
- R2: A data write (reg_wr=1, reg_addr=1) made while the enable bit (ctrl bit 15) is clear has no effect: data_q keeps its value, busy stays low and no tx_strobe appears.
- R3: An accepted transfer keeps busy high for exactly CLK_FREQ >> (19 - rate) clock cycles, where rate is ctrl bits 1:0.
- R4: The busy bit (ctrl_q bit 7, read-only) rises in the cycle after an accepted data write and falls when the transfer completes.
- R5: When the transfer completes, data_q takes the byte that the selected slave returns (rx_bytes[8*cs +: 8]). An accepted write first places the written byte in data_q.
- R6: If the interrupt-enable bit (ctrl bit 14) is set at completion, irq_pulse is high for exactly one cycle, in the cycle where busy first reads low. If that bit is clear, there is no pulse.
- R7: A data write accepted during a transfer cancels the pending completion and restarts the count from zero. No interrupt comes from the cancelled transfer.
- R8: A control write (reg_wr=1, reg_addr=0) made while the stored hold bit (ctrl bit 11) is clear pulses cmd_clr[cs] for one cycle, where cs is the new chip-select field in bits 9:8. The new hold bit is then stored. A control write made while the stored hold bit is set gives no pulse.
- R9: In the cycle after an accepted data write, tx_strobe is high for one cycle with tx_byte equal to the written byte. While busy, dev_sel is one-hot at the latched chip-select, or all zero if no slave is attached at that select.
- R10: A chip-select value with no attached slave (cs >= NUM_DEV) completes with the normal timing and interrupt and loads 0x00 into data_q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects data |
| reg_wdata | input | 16 | Write data (data register uses bits 7:0) |
| ctrl_q | output | 16 | Control register readback, with busy in bit 7 |
| data_q | output | 8 | Data register readback |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| tx_strobe | output | 1 | One-cycle start-of-transfer strobe to slaves |
| tx_byte | output | 8 | Outgoing byte |
| dev_sel | output | NUM_DEV | One-hot slave select while busy |
| cmd_clr | output | NUM_DEV | One-cycle command-state clear per slave |
| rx_bytes | input | 8*NUM_DEV | Bytes returned by the slaves, slave i in bits 8i+7:8i |

## Verification
A wrong count or a wrong latched rate shows as busy (ctrl_q bit 7) falling early or late, so it appears at the ports within one transfer length. A chip-select latched wrongly shows in the first cycle of the transfer as a wrong dev_sel bit, and again at completion as the wrong returned byte in data_q. A stale stored hold bit shows on the next control write, as a cmd_clr pulse that is missing or should not be there. A restart that fails to clear the pending completion shows as busy and irq_pulse arriving one transfer length after the first write rather than after the second.

// File: rtl/spi_xfer_pkg.sv
// Package: shared control-register layout for the SPI transfer controller.
// Assumes the 16-bit control word layout below; unlisted bits read as zero.
package spi_xfer_pkg;

    localparam int CTRL_W     = 16;
    localparam int BIT_ENABLE = 15;
    localparam int BIT_IRQEN  = 14;
    localparam int BIT_HOLD   = 11;
    localparam int CS_LO      = 8;
    localparam int BIT_BUSY   = 7;
    localparam int RATE_LO    = 0;
    localparam int CS_W       = 2;
    localparam int RATE_W     = 2;
    // Transfer length is CLK_FREQ >> (TOP_SHIFT - rate).
    localparam int TOP_SHIFT  = 19;

    typedef struct packed {
        logic              enable;
        logic              irq_en;
        logic              hold;
        logic [CS_W-1:0]   cs;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

endpackage

// File: rtl/spi_ctrl_regs.sv
// Module: control register store with hold-bit command-clear generation.
// Assumes ctrl_wr is a single-cycle write strobe and that NUM_DEV <= 4.
module spi_ctrl_regs
    import spi_xfer_pkg::*;
#(
    parameter int NUM_DEV = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  ctrl_t              ctrl_new,
    output ctrl_t              ctrl,
    output logic [NUM_DEV-1:0] cmd_clr
);

    logic [NUM_DEV-1:0] clr_next;

    // Decode which slave gets a command clear; only when old hold is clear.
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_clr
        assign clr_next[d] = ctrl_wr && !ctrl.hold && (int'(ctrl_new.cs) == d);
    end

    // Store control fields and register the one-cycle clear pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            cmd_clr <= '0;
        end else begin
            cmd_clr <= clr_next;
            if (ctrl_wr) begin
                ctrl <= ctrl_new;
            end
        end
    end

endmodule

// File: rtl/spi_xfer_timer.sv
// Module: transfer timer; counts a latched length and flags completion.
// Assumes len is at least 1. A start during a transfer restarts the count
// and takes priority over a completion due in the same cycle.
module spi_xfer_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             done
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_q;

    // Completion is the last counted cycle of a transfer that is not restarted.
    assign done = busy && !start && (cnt == len_q - CNT_W'(1));

    // Count cycles of the active transfer; start latches length and clears count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            len_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            len_q <= len;
        end else if (done) begin
            busy  <= 1'b0;
            cnt   <= '0;
        end else if (busy) begin
            cnt   <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_dev_port.sv
// Module: per-slave select decode and returned-byte multiplexer.
// Assumes the chip-select latched at transfer start; selects >= NUM_DEV
// have no slave, so they select nothing and return zero.
module spi_dev_port
    import spi_xfer_pkg::*;
#(
    parameter int NUM_DEV = 3
) (
    input  logic                 busy,
    input  logic [CS_W-1:0]      cs_q,
    input  logic [8*NUM_DEV-1:0] rx_bytes,
    output logic [NUM_DEV-1:0]   dev_sel,
    output logic [7:0]           rx_sel
);

    // One select line per attached slave, active only during a transfer.
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_sel
        assign dev_sel[d] = busy && (int'(cs_q) == d);
    end

    // Pick the returned byte of the latched slave, zero if none attached.
    always_comb begin
        rx_sel = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (int'(cs_q) == d) begin
                rx_sel = rx_bytes[8*d +: 8];
            end
        end
    end

endmodule

// File: rtl/spi_xfer_ctrl.sv
// Module: top of the byte-wide SPI master. Decodes register writes, starts
// transfers, captures the returned byte and raises the completion interrupt.
// Assumes CLK_FREQ >> 19 >= 1 and CLK_FREQ >> 16 is small enough to count.
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int NUM_DEV  = 3,
    parameter int CLK_FREQ = 1 << 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          ctrl_q,
    output logic [7:0]           data_q,
    output logic                 irq_pulse,
    output logic                 tx_strobe,
    output logic [7:0]           tx_byte,
    output logic [NUM_DEV-1:0]   dev_sel,
    output logic [NUM_DEV-1:0]   cmd_clr,
    input  logic [8*NUM_DEV-1:0] rx_bytes
);

    localparam int MAX_LEN = CLK_FREQ >> (TOP_SHIFT - ((1 << RATE_W) - 1));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    ctrl_t            ctrl;
    ctrl_t            ctrl_new;
    logic             ctrl_wr;
    logic             accept;
    logic             busy;
    logic             done;
    logic [CS_W-1:0]  cs_q;
    logic [7:0]       rx_sel;
    logic [CNT_W-1:0] xfer_len;
    logic             unused_wbits;

    // Transfer length for a rate code: a power-of-two share of the clock rate.
    function automatic logic [CNT_W-1:0] len_of(input logic [RATE_W-1:0] r);
        return CNT_W'(CLK_FREQ >> (TOP_SHIFT - int'(r)));
    endfunction

    assign ctrl_wr  = reg_wr && !reg_addr;
    assign accept   = reg_wr && reg_addr && ctrl.enable;
    assign xfer_len = len_of(ctrl.rate);
    assign unused_wbits = ^{reg_wdata[13:12], reg_wdata[10]};

    // Unpack a control write into its stored fields.
    always_comb begin
        ctrl_new.enable = reg_wdata[BIT_ENABLE];
        ctrl_new.irq_en = reg_wdata[BIT_IRQEN];
        ctrl_new.hold   = reg_wdata[BIT_HOLD];
        ctrl_new.cs     = reg_wdata[CS_LO +: CS_W];
        ctrl_new.rate   = reg_wdata[RATE_LO +: RATE_W];
    end

    // Build the control readback word with busy in its read-only bit.
    always_comb begin
        ctrl_q                    = '0;
        ctrl_q[BIT_ENABLE]        = ctrl.enable;
        ctrl_q[BIT_IRQEN]         = ctrl.irq_en;
        ctrl_q[BIT_HOLD]          = ctrl.hold;
        ctrl_q[CS_LO +: CS_W]     = ctrl.cs;
        ctrl_q[BIT_BUSY]          = busy;
        ctrl_q[RATE_LO +: RATE_W] = ctrl.rate;
    end

    spi_ctrl_regs #(.NUM_DEV(NUM_DEV)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_new (ctrl_new),
        .ctrl     (ctrl),
        .cmd_clr  (cmd_clr)
    );

    spi_xfer_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .len   (xfer_len),
        .busy  (busy),
        .done  (done)
    );

    spi_dev_port #(.NUM_DEV(NUM_DEV)) u_port (
        .busy     (busy),
        .cs_q     (cs_q),
        .rx_bytes (rx_bytes),
        .dev_sel  (dev_sel),
        .rx_sel   (rx_sel)
    );

    // Data register, outgoing byte, start strobe, latched select and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            tx_byte   <= '0;
            tx_strobe <= 1'b0;
            cs_q      <= '0;
            irq_pulse <= 1'b0;
        end else begin
            tx_strobe <= accept;
            irq_pulse <= done && ctrl.irq_en;
            if (accept) begin
                data_q  <= reg_wdata[7:0];
                tx_byte <= reg_wdata[7:0];
                cs_q    <= ctrl.cs;
            end else if (done) begin
                data_q  <= rx_sel;
            end
        end
    end

endmodule

// File: rtl/spi_xfer_ctrl_chk.sv
// Module: property checker for spi_xfer_ctrl, bound to every instance.
// Observes ports only.
module spi_xfer_ctrl_chk #(
    parameter int NUM_DEV = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic [15:0]        ctrl_q,
    input logic [7:0]         data_q,
    input logic               irq_pulse,
    input logic               tx_strobe,
    input logic [NUM_DEV-1:0] dev_sel,
    input logic [NUM_DEV-1:0] cmd_clr
);

    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && ctrl_q[15]) |=> ctrl_q[7]);

    // R2
    disabled_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && !ctrl_q[15] && !ctrl_q[7]) |=> (!ctrl_q[7] && $stable(data_q) && !tx_strobe));

    // R6
    irq_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $fell(ctrl_q[7]));

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R9
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> ctrl_q[7]);

    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel) && (ctrl_q[7] || dev_sel == '0));

    // R8
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_clr));

endmodule

bind spi_xfer_ctrl spi_xfer_ctrl_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .ctrl_q    (ctrl_q),
    .data_q    (data_q),
    .irq_pulse (irq_pulse),
    .tx_strobe (tx_strobe),
    .dev_sel   (dev_sel),
    .cmd_clr   (cmd_clr)
);

// File: tb/spi_xfer_ctrl_bench.sv
// Bench: directed scenarios for spi_xfer_ctrl, one task per scenario.
module spi_xfer_ctrl_bench;

    localparam int NUM_DEV  = 3;
    localparam int CLK_FREQ = 1 << 22;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 reg_wr = 1'b0;
    logic                 reg_addr = 1'b0;
    logic [15:0]          reg_wdata = '0;
    logic [15:0]          ctrl_q;
    logic [7:0]           data_q;
    logic                 irq_pulse;
    logic                 tx_strobe;
    logic [7:0]           tx_byte;
    logic [NUM_DEV-1:0]   dev_sel;
    logic [NUM_DEV-1:0]   cmd_clr;
    logic [8*NUM_DEV-1:0] rx_bytes = {8'hC3, 8'hB2, 8'hA1};

    int checks = 0;
    int errors = 0;

    spi_xfer_ctrl #(.NUM_DEV(NUM_DEV), .CLK_FREQ(CLK_FREQ)) u_spi_xfer_ctrl (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .ctrl_q, .data_q,
        .irq_pulse, .tx_strobe, .tx_byte, .dev_sel, .cmd_clr, .rx_bytes
    );

    always #5 clk = ~clk;

    // Record one comparison.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cword(input logic en, input logic ie, input logic hold,
                                          input logic [1:0] cs, input logic [1:0] rate);
        logic [15:0] w;
        w = '0;
        w[15] = en; w[14] = ie; w[11] = hold; w[9:8] = cs; w[1:0] = rate;
        return w;
    endfunction

    function automatic int len_of(input int rate);
        return CLK_FREQ >> (19 - rate);
    endfunction

    function automatic logic [7:0] exp_rx(input int cs);
        return (cs < NUM_DEV) ? rx_bytes[8*cs +: 8] : 8'h00;
    endfunction

    // Writes: inputs change at the falling edge, sampled at the next rising edge.
    task automatic wr(input logic addr, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R1 ctrl", ctrl_q, 16'h0000);
        chk("R1 data", data_q, 8'h00);
        chk("R1 irq", irq_pulse, 1'b0);
        chk("R1 strobe", tx_strobe, 1'b0);
        chk("R1 sel", dev_sel, '0);
        chk("R1 clr", cmd_clr, '0);
    endtask

    task automatic t_disabled();
        wr(1'b0, cword(1'b0, 1'b1, 1'b0, 2'd1, 2'd0));
        chk("R8 first clr", cmd_clr, 3'b010);
        wr(1'b1, 16'h005A);
        chk("R2 data", data_q, 8'h00);
        chk("R2 busy", ctrl_q[7], 1'b0);
        chk("R2 strobe", tx_strobe, 1'b0);
        @(negedge clk);
        chk("R2 busy later", ctrl_q[7], 1'b0);
    endtask

    task automatic t_xfer(input int rate, input int cs, input logic ie, input logic [7:0] b);
        int n;
        n = len_of(rate);
        wr(1'b0, cword(1'b1, ie, 1'b1, 2'(cs), 2'(rate)));
        wr(1'b1, {8'h00, b});
        chk("R4 busy set", ctrl_q[7], 1'b1);
        chk("R9 strobe", tx_strobe, 1'b1);
        chk("R9 tx_byte", tx_byte, b);
        chk("R9 sel", dev_sel, (cs < NUM_DEV) ? (3'b001 << cs) : 3'b000);
        chk("R5 written", data_q, b);
        @(negedge clk);
        chk("R9 strobe one", tx_strobe, 1'b0);
        for (int i = 2; i < n; i++) @(negedge clk);
        chk("R3 still busy", ctrl_q[7], 1'b1);
        chk("R6 no early irq", irq_pulse, 1'b0);
        @(negedge clk);
        chk("R3 busy clear", ctrl_q[7], 1'b0);
        chk((cs < NUM_DEV) ? "R5 rx" : "R10 rx", data_q, exp_rx(cs));
        chk((cs < NUM_DEV) ? "R6 irq" : "R10 irq", irq_pulse, ie);
        chk("R9 sel idle", dev_sel, '0);
        @(negedge clk);
        chk("R6 irq one", irq_pulse, 1'b0);
    endtask

    task automatic t_restart();
        int n;
        n = len_of(1);
        wr(1'b0, cword(1'b1, 1'b1, 1'b1, 2'd0, 2'd1));
        wr(1'b1, 16'h0011);
        repeat (3) @(negedge clk);
        wr(1'b1, 16'h0022);
        chk("R7 data rewrite", data_q, 8'h22);
        for (int i = 1; i < n; i++) begin
            if (irq_pulse) chk("R7 no irq", irq_pulse, 1'b0);
            @(negedge clk);
        end
        chk("R7 busy held", ctrl_q[7], 1'b1);
        @(negedge clk);
        chk("R7 done", ctrl_q[7], 1'b0);
        chk("R7 irq", irq_pulse, 1'b1);
        chk("R7 rx", data_q, exp_rx(0));
    endtask

    task automatic t_hold();
        wr(1'b0, cword(1'b1, 1'b0, 1'b1, 2'd2, 2'd0));
        chk("R8 no clr held", cmd_clr, '0);
        wr(1'b0, cword(1'b1, 1'b0, 1'b0, 2'd0, 2'd0));
        chk("R8 no clr prev held", cmd_clr, '0);
        chk("R8 hold stored", ctrl_q[11], 1'b0);
        wr(1'b0, cword(1'b1, 1'b0, 1'b0, 2'd2, 2'd0));
        chk("R8 clr", cmd_clr, 3'b100);
        @(negedge clk);
        chk("R8 clr one", cmd_clr, '0);
        wr(1'b0, cword(1'b1, 1'b0, 1'b0, 2'd3, 2'd0));
        chk("R8 unattached no clr", cmd_clr, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_xfer(0, 0, 1'b1, 8'h3C);
        t_xfer(1, 1, 1'b0, 8'h81);
        t_xfer(2, 2, 1'b1, 8'hF0);
        t_xfer(3, 3, 1'b1, 8'h77);
        t_restart();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule